// File: doc/BRIEF.md
# Trap Cause Prioritizer and Register

This block decides which trap a processor core takes in a given cycle and records why. It watches eleven synchronous exception flags that one instruction may raise, plus a software interrupt line, a timer interrupt line and sixteen platform interrupt lines. When the pipeline offers a trap-accept strobe and at least one candidate is eligible, the block raises a one-cycle trap-taken pulse. On the same clock edge it loads a 32-bit machine cause register. Bit 31 of that register is the interrupt flag and the low bits hold the event code.

Interrupts take part only while the global interrupt enable is high, and an eligible interrupt always beats an exception. Exceptions do not depend on the enable. Among several exceptions from one instruction, a fixed ranking picks a single one. Software can also write the cause register through a plain write port. A write lands only in cycles where no trap is being taken.

Top module: `trap_cause_unit`

## Requirements
- R1: A synchronous active-high reset clears the cause register to 0, and the register reads 0 after reset.
- R2: `trap_taken_o` is high in exactly those cycles where `accept_i` is high and an eligible candidate exists. On that clock edge, `cause_o` loads bit 31 = 1 for an interrupt or 0 for an exception, with the event code zero-extended in bits 30:0.
- R3: Interrupt codes are 3 for the software line, 7 for the timer line, and 16+n for platform line n (n = 0..15).
- R4: Among pending interrupts, the highest-numbered platform line wins, then the timer line, then the software line.
- R5: Interrupts are eligible only while `irq_en_i` is 1. An eligible interrupt is taken ahead of any pending exception.
- R6: Exception codes are: fetch breakpoint 3, fetch access fault 1, uncorrectable ECC error 19, illegal instruction 2, fetch misaligned 0, environment break 3, data breakpoint 3, load access fault 5, store access fault 7, load misaligned 4, store misaligned 6.
- R7: Exception rank, from highest to lowest: fetch breakpoint, fetch access fault, ECC error, illegal instruction, fetch misaligned, environment break, data breakpoint, load access fault, store access fault, load misaligned, store misaligned.
- R8: With `accept_i` low, or with no eligible candidate, there is no pulse. Without a software write, `cause_o` holds its value.
- R9: With `sw_we_i` high and no trap taken, `cause_o` takes all 32 bits of `sw_wdata_i` on the next edge. When a trap is taken in the same cycle, the trap value is loaded and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_bkpt_i | input | 1 | Instruction-address breakpoint hit |
| fetch_fault_i | input | 1 | Instruction fetch access fault |
| ecc_err_i | input | 1 | Uncorrectable ECC hardware error |
| illegal_i | input | 1 | Illegal instruction |
| fetch_misalign_i | input | 1 | Instruction address misaligned |
| ebreak_i | input | 1 | Environment break instruction |
| data_bkpt_i | input | 1 | Load/store address breakpoint hit |
| ld_fault_i | input | 1 | Load access fault |
| st_fault_i | input | 1 | Store access fault |
| ld_misalign_i | input | 1 | Load address misaligned |
| st_misalign_i | input | 1 | Store address misaligned |
| sw_irq_i | input | 1 | Software interrupt pending |
| timer_irq_i | input | 1 | Timer interrupt pending |
| plat_irq_i | input | 16 | Platform interrupt lines, bit n is line n |
| irq_en_i | input | 1 | Global interrupt enable |
| accept_i | input | 1 | Pipeline can take a trap this cycle |
| sw_we_i | input | 1 | Software write enable for the cause register |
| sw_wdata_i | input | 32 | Software write data |
| trap_taken_o | output | 1 | One-cycle pulse when a trap is taken |
| cause_o | output | 32 | Machine cause register value |

## Verification
The assertions check several properties on every cycle. The pulse never appears without the accept strobe. A pending exception under accept always produces a pulse. The register holds when neither a trap nor a write occurs. The interrupt flag follows the enable and the presence of interrupt requests. A platform interrupt always yields a code in the 16 to 31 range. A fetch breakpoint with no eligible interrupt always reports code 3. Only the bench scenarios can show the full ranking between pairs of exceptions, the order among interrupt lines, and the exact code for each source. The same holds for a write colliding with a trap and for reset clearing a value that is not zero.

// File: rtl/trap_cause_pkg.sv
package trap_cause_pkg;

    localparam int XLEN       = 32;
    localparam int CODE_W     = 5;
    localparam int PLAT_LINES = 16;
    localparam int PLAT_BASE  = 16;
    localparam int NUM_EXC    = 11;

    localparam logic [CODE_W-1:0] CODE_SW_IRQ    = CODE_W'(3);
    localparam logic [CODE_W-1:0] CODE_TIMER_IRQ = CODE_W'(7);

    // Exception codes listed in rank order, index 0 is the highest rank.
    localparam logic [CODE_W-1:0] EXC_RANK_CODE [NUM_EXC] = '{
        CODE_W'(3),   // fetch breakpoint
        CODE_W'(1),   // fetch access fault
        CODE_W'(19),  // uncorrectable ECC error
        CODE_W'(2),   // illegal instruction
        CODE_W'(0),   // fetch misaligned
        CODE_W'(3),   // environment break
        CODE_W'(3),   // data breakpoint
        CODE_W'(5),   // load access fault
        CODE_W'(7),   // store access fault
        CODE_W'(4),   // load misaligned
        CODE_W'(6)    // store misaligned
    };

    typedef struct packed {
        logic fetch_bkpt;
        logic fetch_fault;
        logic ecc_err;
        logic illegal;
        logic fetch_misalign;
        logic ebreak;
        logic data_bkpt;
        logic ld_fault;
        logic st_fault;
        logic ld_misalign;
        logic st_misalign;
    } exc_flags_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } pick_t;

    typedef struct packed {
        logic            intr;
        logic [XLEN-2:0] code;
    } cause_t;

    // Flags laid out so that index 0 is the highest rank.
    function automatic logic [NUM_EXC-1:0] rank_vector(exc_flags_t f);
        logic [NUM_EXC-1:0] v;
        v[0]  = f.fetch_bkpt;
        v[1]  = f.fetch_fault;
        v[2]  = f.ecc_err;
        v[3]  = f.illegal;
        v[4]  = f.fetch_misalign;
        v[5]  = f.ebreak;
        v[6]  = f.data_bkpt;
        v[7]  = f.ld_fault;
        v[8]  = f.st_fault;
        v[9]  = f.ld_misalign;
        v[10] = f.st_misalign;
        return v;
    endfunction

    function automatic cause_t make_cause(logic intr, logic [CODE_W-1:0] code);
        cause_t c;
        c.intr = intr;
        c.code = (XLEN-1)'(code);
        return c;
    endfunction

endpackage

// File: rtl/trap_exc_ranker.sv
module trap_exc_ranker
    import trap_cause_pkg::*;
(
    input  exc_flags_t flags_i,
    output pick_t      pick_o
);
    logic [NUM_EXC-1:0] ranked;

    assign ranked = rank_vector(flags_i);

    // Walk from lowest rank up; a later hit overwrites, so rank 0 wins.
    always_comb begin
        pick_o = '0;
        for (int r = NUM_EXC - 1; r >= 0; r--) begin
            if (ranked[r]) begin
                pick_o.valid = 1'b1;
                pick_o.code  = EXC_RANK_CODE[r];
            end
        end
    end

endmodule

// File: rtl/trap_irq_ranker.sv
module trap_irq_ranker
    import trap_cause_pkg::*;
#(
    parameter int LINES = PLAT_LINES,
    parameter int BASE  = PLAT_BASE
) (
    input  logic             sw_i,
    input  logic             timer_i,
    input  logic [LINES-1:0] plat_i,
    output pick_t            pick_o
);
    logic [CODE_W-1:0] line_code [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line_code
        assign line_code[g] = CODE_W'(BASE + g);
    end

    // Lowest priority first; each later hit overrides the earlier one.
    always_comb begin
        pick_o = '0;
        if (sw_i) begin
            pick_o.valid = 1'b1;
            pick_o.code  = CODE_SW_IRQ;
        end
        if (timer_i) begin
            pick_o.valid = 1'b1;
            pick_o.code  = CODE_TIMER_IRQ;
        end
        for (int i = 0; i < LINES; i++) begin
            if (plat_i[i]) begin
                pick_o.valid = 1'b1;
                pick_o.code  = line_code[i];
            end
        end
    end

endmodule

// File: rtl/trap_cause_reg.sv
module trap_cause_reg
    import trap_cause_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  cause_t          load_val_i,
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] q_o
);
    cause_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_i) begin
            q <= load_val_i;
        end else if (we_i) begin
            q <= cause_t'(wdata_i);
        end
    end

    assign q_o = q;

endmodule

// File: rtl/trap_cause_unit.sv
module trap_cause_unit
    import trap_cause_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fetch_bkpt_i,
    input  logic                  fetch_fault_i,
    input  logic                  ecc_err_i,
    input  logic                  illegal_i,
    input  logic                  fetch_misalign_i,
    input  logic                  ebreak_i,
    input  logic                  data_bkpt_i,
    input  logic                  ld_fault_i,
    input  logic                  st_fault_i,
    input  logic                  ld_misalign_i,
    input  logic                  st_misalign_i,
    input  logic                  sw_irq_i,
    input  logic                  timer_irq_i,
    input  logic [PLAT_LINES-1:0] plat_irq_i,
    input  logic                  irq_en_i,
    input  logic                  accept_i,
    input  logic                  sw_we_i,
    input  logic [XLEN-1:0]       sw_wdata_i,
    output logic                  trap_taken_o,
    output logic [XLEN-1:0]       cause_o
);
    exc_flags_t flags;
    pick_t      exc_pick;
    pick_t      irq_pick;
    logic       irq_ok;
    cause_t     next_cause;

    always_comb begin
        flags.fetch_bkpt     = fetch_bkpt_i;
        flags.fetch_fault    = fetch_fault_i;
        flags.ecc_err        = ecc_err_i;
        flags.illegal        = illegal_i;
        flags.fetch_misalign = fetch_misalign_i;
        flags.ebreak         = ebreak_i;
        flags.data_bkpt      = data_bkpt_i;
        flags.ld_fault       = ld_fault_i;
        flags.st_fault       = st_fault_i;
        flags.ld_misalign    = ld_misalign_i;
        flags.st_misalign    = st_misalign_i;
    end

    trap_exc_ranker u_exc (
        .flags_i (flags),
        .pick_o  (exc_pick)
    );

    trap_irq_ranker #(
        .LINES (PLAT_LINES),
        .BASE  (PLAT_BASE)
    ) u_irq (
        .sw_i    (sw_irq_i),
        .timer_i (timer_irq_i),
        .plat_i  (plat_irq_i),
        .pick_o  (irq_pick)
    );

    assign irq_ok = irq_pick.valid & irq_en_i;

    always_comb begin
        if (irq_ok) begin
            next_cause = make_cause(1'b1, irq_pick.code);
        end else begin
            next_cause = make_cause(1'b0, exc_pick.code);
        end
    end

    assign trap_taken_o = accept_i & (irq_ok | exc_pick.valid);

    trap_cause_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (trap_taken_o),
        .load_val_i (next_cause),
        .we_i       (sw_we_i),
        .wdata_i    (sw_wdata_i),
        .q_o        (cause_o)
    );

endmodule

// File: rtl/trap_cause_chk.sv
module trap_cause_chk
    import trap_cause_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  fetch_bkpt_i,
    input logic                  fetch_fault_i,
    input logic                  ecc_err_i,
    input logic                  illegal_i,
    input logic                  fetch_misalign_i,
    input logic                  ebreak_i,
    input logic                  data_bkpt_i,
    input logic                  ld_fault_i,
    input logic                  st_fault_i,
    input logic                  ld_misalign_i,
    input logic                  st_misalign_i,
    input logic                  sw_irq_i,
    input logic                  timer_irq_i,
    input logic [PLAT_LINES-1:0] plat_irq_i,
    input logic                  irq_en_i,
    input logic                  accept_i,
    input logic                  sw_we_i,
    input logic [XLEN-1:0]       sw_wdata_i,
    input logic                  trap_taken_o,
    input logic [XLEN-1:0]       cause_o
);
    logic any_exc;
    logic any_irq;

    assign any_exc = fetch_bkpt_i | fetch_fault_i | ecc_err_i | illegal_i |
                     fetch_misalign_i | ebreak_i | data_bkpt_i | ld_fault_i |
                     st_fault_i | ld_misalign_i | st_misalign_i;
    assign any_irq = sw_irq_i | timer_irq_i | (|plat_irq_i);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> cause_o == '0);

    assert_pulse_needs_accept_R2: assert property (@(posedge clk) disable iff (rst)
        trap_taken_o |-> accept_i);

    assert_exc_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (accept_i && any_exc) |-> trap_taken_o);

    assert_plat_range_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_taken_o && irq_en_i && (|plat_irq_i)) |=>
            (cause_o[31] && cause_o[30:5] == '0 && cause_o[4]));

    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_taken_o && !irq_en_i) |=> !cause_o[31]);

    assert_irq_first_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_taken_o && irq_en_i && any_irq) |=> cause_o[31]);

    assert_top_exc_R7: assert property (@(posedge clk) disable iff (rst)
        (trap_taken_o && fetch_bkpt_i && !(irq_en_i && any_irq)) |=>
            cause_o == 32'd3);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!trap_taken_o && !sw_we_i) |=> $stable(cause_o));

    assert_sw_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!trap_taken_o && sw_we_i) |=> cause_o == $past(sw_wdata_i));

endmodule

bind trap_cause_unit trap_cause_chk chk_i (.*);

// File: tb/trap_cause_unit_tb_top.sv
module trap_cause_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_bkpt, fetch_fault, ecc_err, illegal, fetch_misalign, ebreak;
    logic        data_bkpt, ld_fault, st_fault, ld_misalign, st_misalign;
    logic        sw_irq, timer_irq, irq_en, accept, sw_we;
    logic [15:0] plat_irq;
    logic [31:0] sw_wdata;
    logic        trap_taken;
    logic [31:0] cause;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] mdl_cause = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trap_cause_unit dut_i (
        .clk(clk), .rst(rst),
        .fetch_bkpt_i(fetch_bkpt), .fetch_fault_i(fetch_fault), .ecc_err_i(ecc_err),
        .illegal_i(illegal), .fetch_misalign_i(fetch_misalign), .ebreak_i(ebreak),
        .data_bkpt_i(data_bkpt), .ld_fault_i(ld_fault), .st_fault_i(st_fault),
        .ld_misalign_i(ld_misalign), .st_misalign_i(st_misalign),
        .sw_irq_i(sw_irq), .timer_irq_i(timer_irq), .plat_irq_i(plat_irq),
        .irq_en_i(irq_en), .accept_i(accept), .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
        .trap_taken_o(trap_taken), .cause_o(cause)
    );

    // Reference: returns {taken_candidate, cause value}
    function automatic logic [32:0] ref_pick();
        if (irq_en && (sw_irq || timer_irq || plat_irq != 0)) begin
            for (int n = 15; n >= 0; n--)
                if (plat_irq[n]) return {1'b1, 1'b1, 31'(16 + n)};
            if (timer_irq) return {1'b1, 1'b1, 31'd7};
            return {1'b1, 1'b1, 31'd3};
        end
        if (fetch_bkpt)     return {1'b1, 32'd3};
        if (fetch_fault)    return {1'b1, 32'd1};
        if (ecc_err)        return {1'b1, 32'd19};
        if (illegal)        return {1'b1, 32'd2};
        if (fetch_misalign) return {1'b1, 32'd0};
        if (ebreak)         return {1'b1, 32'd3};
        if (data_bkpt)      return {1'b1, 32'd3};
        if (ld_fault)       return {1'b1, 32'd5};
        if (st_fault)       return {1'b1, 32'd7};
        if (ld_misalign)    return {1'b1, 32'd4};
        if (st_misalign)    return {1'b1, 32'd6};
        return '0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        {fetch_bkpt, fetch_fault, ecc_err, illegal, fetch_misalign, ebreak} = '0;
        {data_bkpt, ld_fault, st_fault, ld_misalign, st_misalign} = '0;
        {sw_irq, timer_irq, irq_en, accept, sw_we} = '0;
        plat_irq = '0;
        sw_wdata = '0;
    endtask

    // Inputs are set at a negedge; check pulse, clock once, check register.
    task automatic step(string req);
        logic [32:0] p;
        logic        exp_take;
        #1;
        p = ref_pick();
        exp_take = accept && p[32];
        check(req, {31'd0, trap_taken}, {31'd0, exp_take});
        if (rst)           mdl_cause = '0;
        else if (exp_take) mdl_cause = p[31:0];
        else if (sw_we)    mdl_cause = sw_wdata;
        @(posedge clk);
        #1;
        check(req, cause, mdl_cause);
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        clear_inputs();
        rst = 1'b1;
        @(negedge clk);
        step("R1 reset");
        rst = 1'b0;
        check("R1 reset value", cause, 32'd0);

        // Each exception alone (R6)
        accept = 1; fetch_bkpt = 1;     step("R6 fetch bkpt");
        accept = 1; fetch_fault = 1;    step("R6 fetch fault");
        accept = 1; ecc_err = 1;        step("R6 ecc");
        accept = 1; illegal = 1;        step("R6 illegal");
        accept = 1; fetch_misalign = 1; step("R6 fetch misalign");
        accept = 1; ebreak = 1;         step("R6 ebreak");
        accept = 1; ld_fault = 1;       step("R6 load fault");
        accept = 1; st_fault = 1;       step("R6 store fault");
        accept = 1; ld_misalign = 1;    step("R6 load misalign");
        accept = 1; st_misalign = 1;    step("R6 store misalign");

        // Ranking pairs (R7)
        accept = 1; fetch_bkpt = 1; fetch_fault = 1;  step("R7 bkpt over fault");
        accept = 1; fetch_fault = 1; ecc_err = 1;     step("R7 fault over ecc");
        accept = 1; ecc_err = 1; illegal = 1;         step("R7 ecc over illegal");
        accept = 1; illegal = 1; fetch_misalign = 1;  step("R7 illegal over misalign");
        accept = 1; fetch_misalign = 1; ebreak = 1;   step("R7 misalign over ebreak");
        accept = 1; data_bkpt = 1; ld_fault = 1;      step("R7 data bkpt over fault");
        accept = 1; ld_fault = 1; st_fault = 1;       step("R7 load over store fault");
        accept = 1; st_fault = 1; ld_misalign = 1;    step("R7 fault over misalign");
        accept = 1; ld_misalign = 1; st_misalign = 1; step("R7 load over store misalign");

        // Interrupts (R3, R4, R5)
        accept = 1; irq_en = 1; sw_irq = 1;        step("R3 software code");
        accept = 1; irq_en = 1; timer_irq = 1;     step("R3 timer code");
        accept = 1; irq_en = 1; plat_irq = 16'h0001; step("R3 line 0");
        accept = 1; irq_en = 1; plat_irq = 16'h8000; step("R3 line 15");
        accept = 1; irq_en = 1; sw_irq = 1; timer_irq = 1; step("R4 timer over sw");
        accept = 1; irq_en = 1; timer_irq = 1; plat_irq = 16'h0024; step("R4 high line wins");
        accept = 1; irq_en = 1; timer_irq = 1; fetch_bkpt = 1; step("R5 irq over exc");
        accept = 1; irq_en = 0; plat_irq = 16'hFFFF; illegal = 1; step("R5 gated irq");
        accept = 1; irq_en = 0; timer_irq = 1;     step("R5 gated, nothing taken");

        // Holding and writes (R8, R9, R2)
        fetch_fault = 1; accept = 0;               step("R8 no accept");
        accept = 1;                                step("R8 nothing pending");
        sw_we = 1; sw_wdata = 32'hDEAD_BEEF;       step("R9 sw write");
        sw_we = 1; sw_wdata = 32'h1234_5678; accept = 1; ld_fault = 1; step("R9 trap beats write");
        accept = 1; irq_en = 1; plat_irq = 16'h0200; step("R2 interrupt flag");

        // Reset from a non-zero value (R1)
        rst = 1; step("R1 reset clears");
        rst = 0;

        // Random mix (R2)
        for (int k = 0; k < 600; k++) begin
            fetch_bkpt     = ($urandom % 12) == 0;
            fetch_fault    = ($urandom % 12) == 0;
            ecc_err        = ($urandom % 12) == 0;
            illegal        = ($urandom % 12) == 0;
            fetch_misalign = ($urandom % 12) == 0;
            ebreak         = ($urandom % 12) == 0;
            data_bkpt      = ($urandom % 12) == 0;
            ld_fault       = ($urandom % 12) == 0;
            st_fault       = ($urandom % 12) == 0;
            ld_misalign    = ($urandom % 12) == 0;
            st_misalign    = ($urandom % 12) == 0;
            sw_irq         = ($urandom % 6) == 0;
            timer_irq      = ($urandom % 6) == 0;
            plat_irq       = (($urandom % 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            irq_en         = $urandom % 2;
            accept         = ($urandom % 4) != 0;
            sw_we          = ($urandom % 4) == 0;
            sw_wdata       = $urandom;
            step("R2 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule